// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item Transfer Engine

This block moves bytes between a configuration item store and system memory under the control of a small descriptor held in memory. Software writes the 64-bit memory address of a descriptor into an address register. The engine fetches the descriptor and optionally re-targets the item selector. It then copies item bytes into memory, copies memory bytes into the item, or steps over item bytes. When it finishes, it stores a completion status word over the descriptor's control field.

The item store, its selector and its byte offset are kept outside the block. The engine asks for a new selector with a one-cycle load pulse and moves the offset forward with one increment pulse per byte. It sees the current item through its validity, length, writability and the byte at the current offset. Memory is reached one byte per request, and each request is held until the memory acknowledges it. Reads of the address-register window return a fixed identification constant.

Top module: `cfgdma_top`

## Requirements
- R1: After reset `busy` is 0, and no memory request is issued while `busy` is 0.
- R2: A read of the register window with offset `o` and size `s` (1 to 8 bytes) returns bytes `o` to `o+s-1` of the 64-bit constant SIGNATURE (byte 0 = most significant), right-aligned. Any offset and size that reach past byte 7 return 0.
- R3: A 4-byte write at offset 0 sets the address register to the written value in the upper half and zero in the lower half. A 4-byte write at offset 4 ORs the written value into the lower half and starts a transfer. An 8-byte write at offset 0 loads the whole address and starts a transfer. Every other register write has no effect.
- R4: The address register reads as zero once a transfer has started. A later lone 4-byte write at offset 4 therefore starts from exactly the written lower half.
- R5: The descriptor is 16 bytes, all big-endian: bytes 0-3 hold the control word, bytes 4-7 the length and bytes 8-15 the memory address. Control bit 1 requests a read of the item, bit 4 a write into the item, bit 2 a skip and bit 3 a selector load; bits 31:16 carry the selector.
- R6: With bit 3 set, the selector is loaded (offset returning to 0) before any byte moves.
- R7: Read takes priority over write, and write over skip. With none of the three bits set, no byte moves and the status is 0.
- R8: A read stores item bytes from the current offset into ascending memory addresses. Bytes past the item's end, or from an invalid item, are stored as 0, and the offset then stays put.
- R9: A skip advances the offset once per byte, never past the item's end, and makes no memory access.
- R10: A write with nonzero length needs a valid item, an offset inside it, write permission and a length no larger than the bytes remaining. Otherwise the status is 1 and neither the item nor the offset changes.
- R11: A memory error on any descriptor byte ends the transfer with status 1 and no data movement. A memory error on a data byte stops the transfer at that byte with status 1.
- R12: The status word (0 on success, 1 on error) is written big-endian to the four bytes at the descriptor address, and `busy` then falls.
- R13: Register writes that arrive while `busy` is 1 are ignored.
- R14: A memory request keeps its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Byte offset within the register window |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Read data (signature extract), combinational |
| busy | output | 1 | A transfer is in progress |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Store data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Completed request failed (valid with mem_ack) |
| mem_rdata | input | 8 | Load data (valid with mem_ack) |
| sel_load | output | 1 | Load a new selector and zero the offset |
| sel_value | output | 16 | Selector to load |
| item_valid | input | 1 | Current selector names an existing item |
| item_len | input | 32 | Length of the current item in bytes |
| item_off | input | 32 | Current byte offset |
| item_writable | input | 1 | Current item accepts writes |
| item_rdata | input | 8 | Item byte at the current offset |
| item_wr_en | output | 1 | Store `item_wdata` at the current offset |
| item_wdata | output | 8 | Byte to store into the item |
| off_inc | output | 1 | Advance the offset by one |

## Verification
The bench builds the block with its defaults: 64-bit addresses, 32-bit lengths, 16-bit selectors and a 4-byte status word. It attaches a 256-byte memory with one wait state and a load-error window, plus two items of 4 and 8 bytes. Those short items let transfers of a few bytes run off the end, hit an exact fit, and overflow by one byte. The error window makes both a failed descriptor fetch and a failed data load reachable.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEL,
        ST_PLAN,
        ST_MOVE,
        ST_STAT
    } cfgdma_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RD,
        OP_WR,
        OP_SKIP
    } cfgdma_op_e;

    localparam int CTL_RD_BIT   = 1;
    localparam int CTL_SKIP_BIT = 2;
    localparam int CTL_SEL_BIT  = 3;
    localparam int CTL_WR_BIT   = 4;

endpackage

// File: rtl/cfgdma_sigread.sv
module cfgdma_sigread #(
    parameter int          WIN_BYTES = 8,
    parameter logic [63:0] SIGNATURE = 64'h0123_4567_89AB_CDEF
) (
    input  logic [2:0]  rd_off,
    input  logic [3:0]  rd_size,
    output logic [63:0] rd_data
);
    localparam int WIN_W = WIN_BYTES * 8;

    int          o_i;
    int          s_i;
    logic [63:0] shifted;
    logic [63:0] mask;

    always_comb begin
        o_i     = int'(rd_off);
        s_i     = int'(rd_size);
        rd_data = '0;
        shifted = '0;
        mask    = '0;
        if (s_i >= 1 && (o_i + s_i) <= WIN_BYTES) begin
            shifted = SIGNATURE >> ((WIN_BYTES - o_i - s_i) * 8);
            mask    = (s_i * 8 >= WIN_W) ? {64{1'b1}} : ((64'd1 << (s_i * 8)) - 64'd1);
            rd_data = shifted & mask;
        end
    end
endmodule

// File: rtl/cfgdma_regif.sv
module cfgdma_regif #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_off,
    input  logic [3:0]        reg_size,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              busy,
    output logic              start_o,
    output logic [ADDR_W-1:0] launch_o
);
    localparam int HALF_W = ADDR_W / 2;
    localparam int HALF_B = HALF_W / 8;
    localparam int FULL_B = ADDR_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] launch;
        logic              start;
    } regif_t;

    regif_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (reg_wr && !busy) begin
            if (reg_size == 4'(HALF_B) && reg_off == 3'd0) begin
                d.addr = {reg_wdata[HALF_W-1:0], {HALF_W{1'b0}}};
            end else if (reg_size == 4'(HALF_B) && reg_off == 3'(HALF_B)) begin
                d.launch = q.addr | {{HALF_W{1'b0}}, reg_wdata[HALF_W-1:0]};
                d.addr   = '0;
                d.start  = 1'b1;
            end else if (reg_size == 4'(FULL_B) && reg_off == 3'd0) begin
                d.launch = reg_wdata;
                d.addr   = '0;
                d.start  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_o  = q.start;
    assign launch_o = q.launch;

    // A launch blocks further launches until the engine is done (R13)
    assert_single_launch_R13: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

endmodule

// File: rtl/cfgdma_core.sv
module cfgdma_core
    import cfgdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32,
    parameter int SEL_W  = 16,
    parameter int CTL_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              core_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    output logic              sel_load,
    output logic [SEL_W-1:0]  sel_value,
    input  logic              item_valid,
    input  logic [LEN_W-1:0]  item_len,
    input  logic [LEN_W-1:0]  item_off,
    input  logic              item_writable,
    input  logic [7:0]        item_rdata,
    output logic              item_wr_en,
    output logic [7:0]        item_wdata,
    output logic              off_inc
);
    localparam int DESC_W     = CTL_W + LEN_W + ADDR_W;
    localparam int DESC_BYTES = DESC_W / 8;
    localparam int STAT_BYTES = CTL_W / 8;
    localparam int IDX_W      = $clog2(DESC_BYTES);
    localparam int LEN_LSB    = ADDR_W;
    localparam int CTL_LSB    = ADDR_W + LEN_W;

    typedef struct packed {
        cfgdma_state_e     st;
        logic [IDX_W-1:0]  idx;
        logic [DESC_W-1:0] desc;
        logic [ADDR_W-1:0] daddr;
        logic [ADDR_W-1:0] maddr;
        logic [LEN_W-1:0]  len;
        cfgdma_op_e        op;
        logic              err;
    } core_t;

    core_t q, d;

    logic              in_rng;
    logic [CTL_W-1:0]  stat_word;
    logic [CTL_W-1:0]  ctl;

    assign in_rng    = item_valid && (item_off < item_len);
    assign stat_word = CTL_W'(q.err);
    assign ctl       = q.desc[CTL_LSB +: CTL_W];

    always_comb begin
        d          = q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = q.maddr;
        mem_wdata  = 8'h00;
        sel_load   = 1'b0;
        sel_value  = ctl[CTL_W-1 -: SEL_W];
        item_wr_en = 1'b0;
        item_wdata = mem_rdata;
        off_inc    = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_FETCH;
                    d.daddr = start_addr;
                    d.idx   = '0;
                    d.err   = 1'b0;
                end
            end

            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.daddr + ADDR_W'(q.idx);
                if (mem_ack) begin
                    if (mem_err) begin
                        d.err = 1'b1;
                        d.idx = '0;
                        d.st  = ST_STAT;
                    end else begin
                        d.desc = {q.desc[DESC_W-9:0], mem_rdata};
                        d.idx  = q.idx + 1'b1;
                        if (q.idx == IDX_W'(DESC_BYTES - 1)) d.st = ST_SEL;
                    end
                end
            end

            ST_SEL: begin
                sel_load = ctl[CTL_SEL_BIT];
                d.maddr  = q.desc[ADDR_W-1:0];
                d.len    = q.desc[LEN_LSB +: LEN_W];
                if      (ctl[CTL_RD_BIT])   d.op = OP_RD;
                else if (ctl[CTL_WR_BIT])   d.op = OP_WR;
                else if (ctl[CTL_SKIP_BIT]) d.op = OP_SKIP;
                else begin
                    d.op  = OP_NONE;
                    d.len = '0;
                end
                d.st = ST_PLAN;
            end

            ST_PLAN: begin
                if (q.op == OP_WR && q.len != '0) begin
                    if (!in_rng || !item_writable || q.len > (item_len - item_off))
                        d.err = 1'b1;
                end
                d.idx = '0;
                if (d.err || q.len == '0) d.st = ST_STAT;
                else                      d.st = ST_MOVE;
            end

            ST_MOVE: begin
                unique case (q.op)
                    OP_RD: begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_wdata = in_rng ? item_rdata : 8'h00;
                    end
                    OP_WR: begin
                        mem_req = 1'b1;
                    end
                    default: ;
                endcase
                if (q.op == OP_SKIP || mem_ack) begin
                    if (mem_req && mem_err) begin
                        d.err = 1'b1;
                        d.st  = ST_STAT;
                    end else begin
                        item_wr_en = (q.op == OP_WR);
                        off_inc    = (q.op == OP_WR) || in_rng;
                        d.maddr    = q.maddr + 1'b1;
                        d.len      = q.len - 1'b1;
                        if (q.len == LEN_W'(1)) d.st = ST_STAT;
                    end
                end
            end

            ST_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.daddr + ADDR_W'(q.idx);
                mem_wdata = 8'(stat_word >> (8 * (STAT_BYTES - 1 - int'(q.idx))));
                if (mem_ack) begin
                    d.idx = q.idx + 1'b1;
                    if (q.idx == IDX_W'(STAT_BYTES - 1)) d.st = ST_IDLE;
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign core_busy = (q.st != ST_IDLE);

    // Request stays put until acknowledged (R14)
    assert_mem_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // Item stores only land inside a writable, valid item (R10)
    assert_item_wr_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        item_wr_en |-> item_valid && item_writable && (item_off < item_len));

    // Offset never advances past the item end (R9)
    assert_off_in_item_R9: assert property (@(posedge clk) disable iff (!rst_n)
        off_inc |-> item_valid && (item_off < item_len));

    // Selector load precedes any data movement by a quiet cycle (R6)
    assert_sel_before_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_load |=> !off_inc && !mem_req && !item_wr_en);

endmodule

// File: rtl/cfgdma_top.sv
module cfgdma_top #(
    parameter int          ADDR_W    = 64,
    parameter int          LEN_W     = 32,
    parameter int          SEL_W     = 16,
    parameter int          CTL_W     = 32,
    parameter logic [63:0] SIGNATURE = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_off,
    input  logic [3:0]        reg_size,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    output logic              sel_load,
    output logic [SEL_W-1:0]  sel_value,
    input  logic              item_valid,
    input  logic [LEN_W-1:0]  item_len,
    input  logic [LEN_W-1:0]  item_off,
    input  logic              item_writable,
    input  logic [7:0]        item_rdata,
    output logic              item_wr_en,
    output logic [7:0]        item_wdata,
    output logic              off_inc
);
    logic              start;
    logic [ADDR_W-1:0] launch_addr;
    logic              core_busy;

    assign busy = core_busy | start;

    cfgdma_sigread #(
        .WIN_BYTES (ADDR_W / 8),
        .SIGNATURE (SIGNATURE)
    ) u_sig (
        .rd_off  (reg_off),
        .rd_size (reg_size),
        .rd_data (reg_rdata)
    );

    cfgdma_regif #(
        .ADDR_W (ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_off   (reg_off),
        .reg_size  (reg_size),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .start_o   (start),
        .launch_o  (launch_addr)
    );

    cfgdma_core #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .SEL_W  (SEL_W),
        .CTL_W  (CTL_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_addr    (launch_addr),
        .core_busy     (core_busy),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_err       (mem_err),
        .mem_rdata     (mem_rdata),
        .sel_load      (sel_load),
        .sel_value     (sel_value),
        .item_valid    (item_valid),
        .item_len      (item_len),
        .item_off      (item_off),
        .item_writable (item_writable),
        .item_rdata    (item_rdata),
        .item_wr_en    (item_wr_en),
        .item_wdata    (item_wdata),
        .off_inc       (off_inc)
    );

    // Memory stays silent whenever the engine is idle (R1)
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

// File: tb/cfgdma_top_tb.sv
module cfgdma_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_off = '0;
    logic [3:0]  reg_size = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        busy;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        sel_load, item_valid, item_writable, item_wr_en, off_inc;
    logic [15:0] sel_value;
    logic [31:0] item_len, item_off;
    logic [7:0]  item_rdata, item_wdata;

    always #10 clk = ~clk; // 50 MHz

    cfgdma_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .sel_load(sel_load), .sel_value(sel_value),
        .item_valid(item_valid), .item_len(item_len), .item_off(item_off),
        .item_writable(item_writable), .item_rdata(item_rdata),
        .item_wr_en(item_wr_en), .item_wdata(item_wdata), .off_inc(off_inc)
    );

    // ---------------- memory model: 256 bytes, one wait state ----------------
    logic [7:0] mem [0:255];
    logic       wait_q;
    logic       tb_we = 1'b0;
    logic [7:0] tb_a = '0;
    logic [7:0] tb_d = '0;

    assign mem_ack   = mem_req && wait_q;
    assign mem_err   = (mem_addr[63:8] != '0) || (!mem_we && mem_addr[7:4] == 4'hE);
    assign mem_rdata = mem[mem_addr[7:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
            for (int k = 0; k < 256; k++) mem[k] <= 8'h00;
        end else begin
            wait_q <= mem_req && !wait_q;
            if (tb_we) mem[tb_a] <= tb_d;
            if (mem_ack && mem_we && !mem_err) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    // ---------------- item model: item 0 (4 B, RO), item 1 (8 B, RW) --------
    logic [15:0] tb_sel;
    logic [31:0] tb_off;
    logic [7:0]  it1 [0:7];

    assign item_valid    = (tb_sel < 16'd2);
    assign item_len      = (tb_sel == 16'd0) ? 32'd4 : 32'd8;
    assign item_writable = (tb_sel == 16'd1);
    assign item_off      = tb_off;
    assign item_rdata    = (tb_sel == 16'd0) ? (8'hA0 + tb_off[7:0]) :
                           (tb_sel == 16'd1) ? it1[tb_off[2:0]] : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_sel <= '0;
            tb_off <= '0;
            for (int k = 0; k < 8; k++) it1[k] <= 8'h10 + 8'(k);
        end else begin
            if (sel_load) begin
                tb_sel <= sel_value;
                tb_off <= '0;
            end else if (off_inc) begin
                tb_off <= tb_off + 32'd1;
            end
            if (item_wr_en && tb_sel == 16'd1) it1[tb_off[2:0]] <= item_wdata;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input int a);
        return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
    endfunction

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_a = a; tb_d = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [7:0] base, input logic [31:0] ctl,
                            input logic [31:0] len, input logic [63:0] ma);
        logic [127:0] img;
        img = {ctl, len, ma};
        for (int k = 0; k < 16; k++) poke(base + 8'(k), img[127 - 8*k -: 8]);
    endtask

    task automatic reg_write(input logic [2:0] o, input logic [3:0] s, input logic [63:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = o; reg_size = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " completion"}, 64'(busy), 64'd0);
    endtask

    task automatic sig_read(input logic [2:0] o, input logic [3:0] s, input logic [63:0] exp);
        @(negedge clk);
        reg_off = o; reg_size = s;
        #2;
        chk("R2 signature", reg_rdata, exp);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] len;
        logic [7:0]  maddr;
        logic [31:0] stat;
        logic [31:0] off;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_000A, 32'd4, 8'h40, 32'd0, 32'd4}, // R8 full read
        '{32'h0000_000A, 32'd6, 8'h40, 32'd0, 32'd4}, // R8 read past end
        '{32'h0002_000A, 32'd3, 8'h40, 32'd0, 32'd0}, // R8 invalid item
        '{32'h0000_000C, 32'd2, 8'h40, 32'd0, 32'd2}, // R9 skip
        '{32'h0001_0018, 32'd8, 8'h40, 32'd0, 32'd8}, // R10 exact-fit write
        '{32'h0000_0018, 32'd2, 8'h40, 32'd1, 32'd0}, // R10 read-only
        '{32'h0001_0018, 32'd9, 8'h40, 32'd1, 32'd0}, // R10 too long
        '{32'h0002_0018, 32'd1, 8'h40, 32'd1, 32'd0}, // R10 invalid item
        '{32'h0000_0008, 32'd5, 8'h40, 32'd0, 32'd0}, // R7 no op
        '{32'h0000_001A, 32'd2, 8'h40, 32'd0, 32'd2}, // R7 read beats write
        '{32'h0000_001C, 32'd1, 8'h40, 32'd1, 32'd0}, // R7 write beats skip
        '{32'h0000_000A, 32'd0, 8'h40, 32'd0, 32'd0}, // R7 zero length
        '{32'h0001_0018, 32'd2, 8'hE0, 32'd1, 32'd0}  // R11 data load error
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] off_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R1 no request after reset", 64'(mem_req), 64'd0);

        // R2 signature window
        sig_read(3'd0, 4'd8, 64'h0123_4567_89AB_CDEF);
        sig_read(3'd4, 4'd4, 64'h0000_0000_89AB_CDEF);
        sig_read(3'd6, 4'd1, 64'h0000_0000_0000_00CD);
        sig_read(3'd6, 4'd4, 64'h0);

        // Table walk, each launched with an 8-byte write (R3, R5, R12)
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < 16; k++) poke(8'h40 + 8'(k), 8'h55 + 8'(k));
            put_desc(8'h10, VEC[i].ctl, VEC[i].len, 64'(VEC[i].maddr));
            reg_write(3'd0, 4'd8, 64'h10);
            wait_idle("R12");
            chk($sformatf("R12 status vector %0d", i), 64'(word_at(8'h10)), 64'(VEC[i].stat));
            chk($sformatf("R6 offset vector %0d", i), 64'(tb_off), 64'(VEC[i].off));
            if (i == 0)
                for (int k = 0; k < 4; k++)
                    chk("R8 item bytes", 64'(mem[8'h40 + k]), 64'(8'hA0 + 8'(k)));
            if (i == 1) begin
                chk("R8 zero fill", 64'(mem[8'h44]), 64'h0);
                chk("R8 zero fill", 64'(mem[8'h45]), 64'h0);
                chk("R8 no overrun", 64'(mem[8'h46]), 64'h5B);
            end
            if (i == 2) chk("R8 invalid zero", 64'(mem[8'h41]), 64'h0);
            if (i == 3) chk("R9 skip leaves memory", 64'(mem[8'h40]), 64'h55);
            if (i == 4)
                for (int k = 0; k < 8; k++)
                    chk("R10 item written", 64'(it1[k]), 64'(8'h55 + 8'(k)));
        end

        // R10 failed writes left item 1 untouched
        chk("R10 item unchanged", 64'(it1[0]), 64'h55);

        // R3 split write: upper half 0, lower half 0x10
        put_desc(8'h10, 32'h0000_000C, 32'd1, 64'h40);
        reg_write(3'd0, 4'd4, 64'h0);
        chk("R3 upper half does not start", 64'(busy), 64'd0);
        reg_write(3'd4, 4'd4, 64'h10);
        wait_idle("R3");
        chk("R3 split launch status", 64'(word_at(8'h10)), 64'h0);

        // R4 address cleared: lone lower half 0x20 must not hit 0x30
        put_desc(8'h20, 32'h0000_000C, 32'd1, 64'h40);
        for (int k = 0; k < 4; k++) poke(8'h30 + 8'(k), 8'hFF);
        reg_write(3'd4, 4'd4, 64'h20);
        wait_idle("R4");
        chk("R4 cleared address used", 64'(word_at(8'h20)), 64'h0);
        chk("R4 stale address unused", 64'(word_at(8'h30)), 64'hFFFF_FFFF);

        // R3 unsupported size has no effect
        reg_write(3'd0, 4'd2, 64'h10);
        chk("R3 2-byte write ignored", 64'(busy), 64'd0);

        // R13 write during busy ignored
        put_desc(8'h10, 32'h0000_000A, 32'd4, 64'h40);
        reg_write(3'd0, 4'd8, 64'h10);
        reg_write(3'd0, 4'd8, 64'h30);
        wait_idle("R13");
        repeat (60) @(negedge clk);
        chk("R13 busy write ignored", 64'(word_at(8'h30)), 64'hFFFF_FFFF);
        chk("R13 first transfer done", 64'(word_at(8'h10)), 64'h0);

        // R11 descriptor fetch error
        for (int k = 0; k < 4; k++) poke(8'hE0 + 8'(k), 8'hFF);
        off_before = tb_off;
        reg_write(3'd0, 4'd8, 64'hE0);
        wait_idle("R11");
        chk("R11 fetch error status", 64'(word_at(8'hE0)), 64'h1);
        chk("R11 no movement", 64'(tb_off), 64'(off_before));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule